// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Dispatcher

This block works next to an 8-bit CPU sequencer. At the end of each instruction it decides whether the CPU should enter an interrupt service routine instead of fetching the next opcode. It holds two registers on a byte-wide memory-mapped bus:

- a pending-request register, which peripherals set by pulsing request lines;
- a source-mask register, written by software.

It also holds a master enable bit. The CPU changes that bit with three strobes: enable, disable and return-and-enable.

The CPU side is reduced to handshake signals. The sequencer raises `cpu_boundary` in the cycle an opcode byte has fully executed. It raises `cpu_prefix` together with it when that byte was only the 0xCB prefix of a two-byte opcode. When a routine is taken, the block answers in the following cycle with a one-cycle `irq_take`, plus three values: the source number, the vector the CPU should jump to, and a one-hot clear mask naming the serviced request bit. It clears that bit and the master enable on the same clock edge.

Top module: `irq_dispatch`

## Requirements
- R1: After reset the request and mask registers hold zero, the master enable is off, and `irq_take` and `irq_clear` are low.
- R2: Address 0xFF0F holds the five request bits in bits 4..0, and bits 7..5 read back as 1. Address 0xFFFF holds the five mask bits in bits 4..0, and bits 7..5 read back as 0. Any other address reads 0x00 and ignores writes. Reads are combinational on `bus_addr`.
- R3: A high `irq_req[n]` sets request bit n at the next edge, whatever the master enable. If a bus write to 0xFF0F happens in the same cycle, the request still sets its bit on top of the written value.
- R4: A routine is taken only on a qualified boundary (`cpu_boundary` high, `cpu_prefix` low) while the master enable is on and (request AND mask) is nonzero.
- R5: A boundary flagged with `cpu_prefix` never takes a routine and does not count toward a delayed enable.
- R6: When several sources are both requested and unmasked, the lowest-numbered one is served (bit 0 first, bit 4 last).
- R7: In the cycle after the deciding boundary, `irq_take` is high for one cycle. In that cycle `irq_id` holds the source n, `irq_vector` holds 0x0040 + 8*n, and `irq_clear` holds the one-hot mask 1<<n.
- R8: Taking a routine clears request bit n and the master enable on the same edge. Other request bits are untouched.
- R9: An enable strobe arms a delayed enable. The master enable turns on at the first qualified boundary after the strobe cycle, and that boundary is still decided with the enable off.
- R10: Return-and-enable turns the master enable on at the next edge and drops any armed enable. Disable turns it off and drops any armed enable. For the master enable, disable outranks a take, which outranks return-and-enable, which outranks an armed enable completing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_req | input | 5 | Request pulses from peripherals |
| cpu_boundary | input | 1 | Current opcode byte has fully executed |
| cpu_prefix | input | 1 | That byte was a 0xCB prefix |
| cpu_ei | input | 1 | Delayed enable strobe |
| cpu_di | input | 1 | Disable strobe |
| cpu_reti | input | 1 | Return-and-enable strobe |
| irq_take | output | 1 | Routine entry, one cycle |
| irq_id | output | 3 | Served source number |
| irq_vector | output | 16 | Routine entry address |
| irq_clear | output | 5 | One-hot serviced request bit |
| ime_on | output | 1 | Master enable state |

## Verification
The bench goes after the corner cases where a plausible mistake changes what the CPU sees:

- **Prefix boundary.** The bench puts a prefix boundary right in front of a pending request. A design that treats the prefix as a boundary would split a two-byte opcode by entering a routine there.
- **Enable strobe.** The bench issues the enable strobe while a request is already pending. A design that enables at once, or that counts a prefix boundary toward the delay, takes a routine one instruction early.
- **Simultaneous requests and masking.** Several sources are raised together, with a mask that hides the highest-priority one. A reversed priority order or a mask applied in the wrong place then shows up as a wrong vector.
- **Request during a write.** A request is pulsed in the same cycle the request register is written. Letting the write win would lose that request.
- **Disable after enable.** Disable follows an armed enable. A design that keeps the arm would turn the enable back on at the next boundary.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;

   // Default register locations on the byte bus
   localparam logic [15:0] REQ_REG_ADDR  = 16'hFF0F;
   localparam logic [15:0] MASK_REG_ADDR = 16'hFFFF;

   // Master-enable action chosen in one cycle, highest rank first
   typedef enum logic [2:0] {
      ME_OFF_DI,
      ME_OFF_TAKE,
      ME_ON_RETI,
      ME_ON_DELAYED,
      ME_KEEP
   } me_action_e;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int N    = 5,
   parameter int ID_W = 3
) (
   input  logic [N-1:0]    req,
   output logic            any,
   output logic [ID_W-1:0] id,
   output logic [N-1:0]    onehot
);

   assign any = |req;

   // lowest set bit wins
   always_comb begin
      id = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) id = ID_W'(i);
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_bit
      if (g == 0) begin : g_first
         assign onehot[g] = req[g];
      end else begin : g_rest
         assign onehot[g] = req[g] & ~(|req[g-1:0]);
      end
   end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int              N         = 5,
   parameter int              DATA_W    = 8,
   parameter int              ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] REQ_ADDR  = 16'hFF0F,
   parameter logic [ADDR_W-1:0] MASK_ADDR = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [N-1:0]      req_set,
   input  logic [N-1:0]      svc_clr,
   output logic [DATA_W-1:0] rdata,
   output logic [N-1:0]      req_q,
   output logic [N-1:0]      mask_q
);

   localparam logic [DATA_W-1:0] PAD_ONES = ~DATA_W'((1 << N) - 1);

   logic          hit_req, hit_mask;
   logic [N-1:0]  req_nxt;

   assign hit_req  = (addr == REQ_ADDR);
   assign hit_mask = (addr == MASK_ADDR);

   if (DATA_W > N) begin : g_pad
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata[DATA_W-1:N];
   end

   // write first, then service clear, then new requests on top
   always_comb begin
      req_nxt = (wr && hit_req) ? wdata[N-1:0] : req_q;
      req_nxt = (req_nxt & ~svc_clr) | req_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= '0;
         mask_q <= '0;
      end else begin
         req_q <= req_nxt;
         if (wr && hit_mask) mask_q <= wdata[N-1:0];
      end
   end

   always_comb begin
      if (hit_req)       rdata = PAD_ONES | DATA_W'(req_q);
      else if (hit_mask) rdata = DATA_W'(mask_q);
      else               rdata = '0;
   end

endmodule

// File: rtl/irq_master_en.sv
module irq_master_en
   import irq_disp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic qual,
   input  logic take,
   input  logic ei,
   input  logic di,
   input  logic reti,
   output logic ime
);

   logic       armed_q;
   me_action_e act;

   always_comb begin
      if (di)                    act = ME_OFF_DI;
      else if (take)             act = ME_OFF_TAKE;
      else if (reti)             act = ME_ON_RETI;
      else if (armed_q && qual)  act = ME_ON_DELAYED;
      else                       act = ME_KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ime     <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         unique case (act)
            ME_OFF_DI, ME_OFF_TAKE: begin
               ime     <= 1'b0;
               armed_q <= 1'b0;
            end
            ME_ON_RETI, ME_ON_DELAYED: begin
               ime     <= 1'b1;
               armed_q <= 1'b0;
            end
            default: ;
         endcase
         if (ei && !di) armed_q <= 1'b1;
      end
   end

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
   import irq_disp_pkg::*;
#(
   parameter int                NUM_SRC    = 5,
   parameter int                DATA_W     = 8,
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] REQ_ADDR   = REQ_REG_ADDR,
   parameter logic [ADDR_W-1:0] MASK_ADDR  = MASK_REG_ADDR,
   parameter logic [ADDR_W-1:0] VEC_BASE   = 16'h0040,
   parameter int                VEC_STRIDE = 8,
   localparam int               ID_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic               cpu_boundary,
   input  logic               cpu_prefix,
   input  logic               cpu_ei,
   input  logic               cpu_di,
   input  logic               cpu_reti,
   output logic               irq_take,
   output logic [ID_W-1:0]    irq_id,
   output logic [ADDR_W-1:0]  irq_vector,
   output logic [NUM_SRC-1:0] irq_clear,
   output logic               ime_on
);

   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("irq_dispatch: NUM_SRC must be 1..DATA_W");
   end
   if (VEC_STRIDE < 1) begin : g_bad_stride
      $error("irq_dispatch: VEC_STRIDE must be positive");
   end
   if (REQ_ADDR == MASK_ADDR) begin : g_bad_map
      $error("irq_dispatch: register addresses collide");
   end

   logic [NUM_SRC-1:0] req_w, mask_w, pend_w, onehot_w, clr_w;
   logic               any_w, qual_w, take_w;
   logic [ID_W-1:0]    id_w;
   logic [ADDR_W-1:0]  vec_w;

   irq_flag_bank #(
      .N(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .REQ_ADDR(REQ_ADDR), .MASK_ADDR(MASK_ADDR)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
      .req_set(irq_req), .svc_clr(clr_w),
      .rdata(bus_rdata), .req_q(req_w), .mask_q(mask_w)
   );

   assign pend_w = req_w & mask_w;

   irq_prio_enc #(.N(NUM_SRC), .ID_W(ID_W)) u_prio (
      .req(pend_w), .any(any_w), .id(id_w), .onehot(onehot_w)
   );

   // a prefix byte does not end an instruction
   assign qual_w = cpu_boundary & ~cpu_prefix;
   assign take_w = qual_w & ime_on & any_w;
   assign clr_w  = take_w ? onehot_w : '0;
   assign vec_w  = VEC_BASE + ADDR_W'(id_w) * ADDR_W'(VEC_STRIDE);

   irq_master_en u_me (
      .clk(clk), .rst_n(rst_n),
      .qual(qual_w), .take(take_w),
      .ei(cpu_ei), .di(cpu_di), .reti(cpu_reti),
      .ime(ime_on)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_take   <= 1'b0;
         irq_id     <= '0;
         irq_vector <= '0;
         irq_clear  <= '0;
      end else begin
         irq_take  <= take_w;
         irq_clear <= clr_w;
         if (take_w) begin
            irq_id     <= id_w;
            irq_vector <= vec_w;
         end
      end
   end

endmodule

// File: rtl/irq_disp_chk.sv
module irq_disp_chk #(
   parameter int N = 5
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cpu_boundary,
   input logic         cpu_prefix,
   input logic         cpu_reti,
   input logic         irq_take,
   input logic [N-1:0] irq_clear,
   input logic         ime,
   input logic [N-1:0] pend
);

   // R4: a take needs the master enable at the deciding edge
   p_take_needs_ime_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> $past(ime));

   // R5: a prefix boundary never yields a take
   p_prefix_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cpu_boundary && cpu_prefix) |-> !irq_take);

   // R6: the served bit was pending and no lower bit was
   p_lowest_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> ((((irq_clear - 1'b1) & $past(pend)) == '0) &&
                    ((irq_clear & $past(pend)) != '0)));

   // R7: clear mask is one-hot exactly while a take is reported
   p_clear_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_clear) && (irq_take == (irq_clear != '0)));

   // R8: master enable is off in the cycle a take is reported
   p_take_clears_ime_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> !ime);

   // R9: without a return strobe, enable only rises on a full boundary
   p_delayed_on_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ime) && !$past(cpu_reti)) |-> $past(cpu_boundary && !cpu_prefix));

endmodule

bind irq_dispatch irq_disp_chk #(.N(NUM_SRC)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .cpu_boundary(cpu_boundary), .cpu_prefix(cpu_prefix), .cpu_reti(cpu_reti),
   .irq_take(irq_take), .irq_clear(irq_clear), .ime(ime_on), .pend(pend_w)
);

// File: tb/sim_irq_dispatch.sv
`timescale 1ns/1ps
module sim_irq_dispatch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [4:0]  irq_req = '0;
   logic        cpu_boundary = 1'b0, cpu_prefix = 1'b0;
   logic        cpu_ei = 1'b0, cpu_di = 1'b0, cpu_reti = 1'b0;
   logic        irq_take;
   logic [2:0]  irq_id;
   logic [15:0] irq_vector;
   logic [4:0]  irq_clear;
   logic        ime_on;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_dispatch u0 (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_req(irq_req), .cpu_boundary(cpu_boundary), .cpu_prefix(cpu_prefix),
      .cpu_ei(cpu_ei), .cpu_di(cpu_di), .cpu_reti(cpu_reti),
      .irq_take(irq_take), .irq_id(irq_id), .irq_vector(irq_vector),
      .irq_clear(irq_clear), .ime_on(ime_on)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference ----------------
   int m_req, m_mask, m_ime, m_arm, m_take, m_id, m_clr;
   int pend, win, nreq;
   bit full_bnd, tk;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_req = 0; m_mask = 0; m_ime = 0; m_arm = 0;
         m_take = 0; m_id = 0; m_clr = 0;
      end else begin
         pend = m_req & m_mask;
         full_bnd = cpu_boundary && !cpu_prefix;
         win = -1;
         for (int i = 4; i >= 0; i--) if (pend[i]) win = i;
         tk = full_bnd && (m_ime != 0) && (win >= 0);
         nreq = (bus_wr && bus_addr == 16'hFF0F) ? (bus_wdata & 'h1F) : m_req;
         if (tk) nreq = nreq & ~(1 << win);
         nreq = nreq | irq_req;
         if (bus_wr && bus_addr == 16'hFFFF) m_mask = bus_wdata & 'h1F;
         if (cpu_di || tk) begin m_ime = 0; m_arm = 0; end
         else if (cpu_reti) begin m_ime = 1; m_arm = 0; end
         else if (m_arm != 0 && full_bnd) begin m_ime = 1; m_arm = 0; end
         if (cpu_ei && !cpu_di) m_arm = 1;
         m_req = nreq;
         m_take = tk;
         if (tk) m_id = win;
         m_clr = tk ? (1 << win) : 0;
      end
   end

   // compare every cycle, away from the edge
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         chk("R4 take", irq_take, m_take);
         chk("R8 clear", irq_clear, m_clr);
         chk("R9 enable", ime_on, m_ime);
         chk("R2 rdata", bus_rdata,
             (bus_addr == 16'hFF0F) ? ('hE0 | m_req) :
             (bus_addr == 16'hFFFF) ? m_mask : 0);
         if (m_take != 0) begin
            chk("R7 id", irq_id, m_id);
            chk("R7 vector", irq_vector, 'h40 + 8 * m_id);
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic step(bit bnd = 0, bit pfx = 0, bit ei = 0, bit di = 0, bit reti = 0,
                       logic [4:0] req = 0, bit wr = 0, logic [15:0] a = 0,
                       logic [7:0] d = 0);
      @(negedge clk);
      cpu_boundary = bnd; cpu_prefix = pfx; cpu_ei = ei; cpu_di = di; cpu_reti = reti;
      irq_req = req; bus_wr = wr; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      step(.a(16'hFF0F)); chk("R1 req reg", bus_rdata, 'hE0);
      step(.a(16'hFFFF)); chk("R1 mask reg", bus_rdata, 'h00);
      chk("R1 ime", ime_on, 0); chk("R1 take", irq_take, 0);

      // R2 register map
      step(.wr(1), .a(16'hFFFF), .d(8'hFF)); chk("R2 mask bits", bus_rdata, 'h1F);
      step(.wr(1), .a(16'h1234), .d(8'hFF)); chk("R2 other addr", bus_rdata, 'h00);
      step(.a(16'hFF0F)); chk("R2 req untouched", bus_rdata, 'hE0);

      // R3 requests land with enable off, and beat a same-cycle write
      step(.req(5'b00100), .a(16'hFF0F)); chk("R3 set", bus_rdata, 'hE4);
      step(.bnd(1), .a(16'hFF0F)); chk("R3 no take while off", irq_take, 0);
      step(.req(5'b00010), .wr(1), .a(16'hFF0F), .d(8'h00));
      chk("R3 req over write", bus_rdata, 'hE2);
      step(.wr(1), .a(16'hFF0F), .d(8'h00));

      // R10 return-and-enable is immediate
      step(.reti(1)); chk("R10 reti on", ime_on, 1);
      step(.req(5'b01010));
      // R5 prefix boundary takes nothing
      step(.bnd(1), .pfx(1)); chk("R5 prefix no take", irq_take, 0);
      // R6 lowest of bits 1 and 3
      step(.bnd(1), .a(16'hFF0F));
      chk("R6 take", irq_take, 1); chk("R6 id", irq_id, 1);
      chk("R7 vector", irq_vector, 'h48); chk("R8 req bit cleared", bus_rdata, 'hE8);
      chk("R8 ime off", ime_on, 0);

      // R9 delayed enable; bit 3 pending
      step(.ei(1)); chk("R9 not yet", ime_on, 0);
      step(.bnd(1), .pfx(1)); chk("R9 prefix not counted", ime_on, 0);
      step(.bnd(1)); chk("R9 no take on enabling boundary", irq_take, 0);
      chk("R9 on after boundary", ime_on, 1);
      step(.bnd(1)); chk("R9 take", irq_take, 1); chk("R7 vector 3", irq_vector, 'h58);

      // R10 disable cancels an armed enable
      step(.ei(1)); step(.di(1)); step(.bnd(1)); step(.bnd(1));
      chk("R10 disarmed", ime_on, 0);

      // R6 with mask hiding bit 0; R7 vector of bit 4 later
      step(.wr(1), .a(16'hFFFF), .d(8'h1E));
      step(.req(5'b11111), .reti(1));
      step(.bnd(1)); chk("R6 masked bit0 skipped", irq_id, 1);
      step(.reti(1), .wr(1), .a(16'hFF0F), .d(8'h10));
      step(.bnd(1)); chk("R7 vector 4", irq_vector, 'h60);
      step(.wr(1), .a(16'hFFFF), .d(8'h1F));
      step(.req(5'b00001), .reti(1));
      step(.bnd(1)); chk("R7 vector 0", irq_vector, 'h40);

      // R10 take outranks same-cycle reti
      step(.req(5'b00100), .reti(1));
      step(.bnd(1), .reti(1)); chk("R10 take beats reti", ime_on, 0);
      repeat (3) step();

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R4 watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule